// File: doc/BRIEF.md
# Programmable Array Logic Output Macrocell

This block is one output cell of a small programmable logic array. It receives the product terms that an AND array produces for this cell. It combines them in an OR gate and applies a selectable output polarity. It then presents the result on a tristate I/O pin, either straight through or through a D flip-flop. It also returns one feedback signal to the AND array. Two global configuration bits are shared by every cell of the device. Two per-cell bits choose the cell's mode and its polarity.

The I/O pin is modelled as three separate signals: a pin-in value, a pin-out value and a pin output-enable. The feedback signal can come from the flip-flop, from the cell's own pin, or from the pin of the neighbouring cell. A cell placed at either end of the array has an altered feedback rule, which the `IS_END` parameter selects. Encodings that select no legal mode turn the driver off and raise an error flag.

Top module: `pal_macrocell`

## Requirements
- R1: The mode comes from {cfg_glb_comb, cfg_glb_fam, cfg_cell_sel}. The legal settings are 0,1,0 registered output; 0,1,1 combinational I/O in a registered device; 1,0,0 dedicated combinational output; 1,0,1 dedicated input; 1,1,1 combinational I/O in a non-registered device.
- R2: In registered mode the flip-flop captures (OR of all eight product terms) XOR cfg_cell_inv on each rising clock edge. Both pin_out and fb_out show the flip-flop value, and they do not change between edges.
- R3: In registered mode pin_oe follows glb_oe, which is active high.
- R4: In both combinational I/O modes pin_out is (OR of pt[6:0]) XOR cfg_cell_inv and pin_oe equals pt[7]. glb_oe has no effect on either output.
- R5: In both combinational I/O modes a non-end cell takes fb_out from pin_in.
- R6: In dedicated combinational output mode pin_out is (OR of all eight terms) XOR cfg_cell_inv and pin_oe is 1. A non-end cell takes fb_out from pin_in.
- R7: In dedicated input mode pin_oe is 0, pin_out is 0 and fb_out follows adj_pin_in.
- R8: When cfg_cell_inv is 1 the logic value is inverted (active-low output). When it is 0 the value passes true.
- R9: An end cell (IS_END=1) in dedicated combinational output mode drives fb_out to 0.
- R10: An end cell chooses its feedback with cfg_glb_comb in place of cfg_glb_fam. As a result, in combinational I/O of a non-registered device its fb_out follows adj_pin_in. In its other modes it gives the same feedback as a non-end cell.
- R11: The encodings cfg_glb_comb=0 with cfg_glb_fam=0, and 1,1,0, are illegal. In those cases cfg_err is 1 and pin_oe, pin_out and fb_out are 0. cfg_err is 0 for every legal setting.
- R12: A synchronous active-high rst clears the flip-flop at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock; the flip-flop loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| pt | input | N_PT | Product terms from the AND array; the top bit can serve as output enable |
| glb_oe | input | 1 | Global output-enable pin, active high |
| pin_in | input | 1 | Value seen on this cell's I/O pin |
| adj_pin_in | input | 1 | Value seen on the neighbouring cell's I/O pin |
| cfg_glb_comb | input | 1 | Global bit: 1 selects a non-registered device |
| cfg_glb_fam | input | 1 | Global bit paired with cfg_glb_comb to choose the device type |
| cfg_cell_sel | input | 1 | Per-cell mode bit |
| cfg_cell_inv | input | 1 | Per-cell polarity bit, 1 = active low |
| pin_out | output | 1 | Value driven toward the I/O pin |
| pin_oe | output | 1 | Driver enable for the I/O pin |
| fb_out | output | 1 | Feedback to the AND array |
| cfg_err | output | 1 | High for an illegal configuration |

## Verification
The assertions are checked on every cycle. They cover these rules: an illegal setting and dedicated input always keep the driver off, the I/O modes always take their enable from the top product term, and registered feedback always equals the registered pin value. They also check that, across consecutive registered cycles, the pin shows the value captured at the previous edge, and that an end cell never feeds back in dedicated output mode. The bench scenarios show the rest: the exact pin and feedback values for every mode and polarity, and the difference between end and non-end feedback. They also show that glb_oe has no effect in the I/O modes and that reset clears the flip-flop.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  typedef enum logic [2:0] {
    MD_REG  = 3'd0,
    MD_IOR  = 3'd1,
    MD_COMB = 3'd2,
    MD_DIN  = 3'd3,
    MD_ION  = 3'd4,
    MD_BAD  = 3'd5
  } mc_mode_t;
endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
  import pal_mc_pkg::*;
(
  input  logic     glb_comb,
  input  logic     glb_fam,
  input  logic     cell_sel,
  output mc_mode_t mode,
  output logic     bad
);
  always_comb begin
    case ({glb_comb, glb_fam, cell_sel})
      3'b010:  mode = MD_REG;
      3'b011:  mode = MD_IOR;
      3'b100:  mode = MD_COMB;
      3'b101:  mode = MD_DIN;
      3'b111:  mode = MD_ION;
      default: mode = MD_BAD;
    endcase
    bad = (mode == MD_BAD);
  end
endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum #(
  parameter int N_PT = 8
) (
  input  logic [N_PT-1:0] pt,
  input  logic            inv,
  output logic            sum_all,
  output logic            val_all,
  output logic            val_lo
);
  localparam int LAST = N_PT - 1;

  logic sum_lo;

  always_comb begin
    sum_lo = 1'b0;
    for (int k = 0; k < LAST; k++) sum_lo = sum_lo | pt[k];
    sum_all = sum_lo | pt[LAST];
    val_all = sum_all ^ inv;
    val_lo  = sum_lo ^ inv;
  end
endmodule

// File: rtl/pal_mc_fbsel.sv
module pal_mc_fbsel #(
  parameter bit IS_END = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic glb_comb,
  input  logic glb_fam,
  input  logic cell_sel,
  input  logic bad,
  input  logic q,
  input  logic pin_in,
  input  logic adj_pin_in,
  output logic fb
);
  logic key;

  assign key = IS_END ? ~glb_comb : glb_fam;

  generate
    if (IS_END) begin : g_end
      always_comb begin
        case ({key, cell_sel})
          2'b10:   fb = q;
          2'b11:   fb = pin_in;
          2'b01:   fb = adj_pin_in;
          default: fb = 1'b0;
        endcase
        if (bad) fb = 1'b0;
      end
      AST_END_NO_FB: assert property (@(posedge clk) disable iff (rst)
        ({glb_comb, glb_fam, cell_sel} == 3'b100) |-> !fb); // R9
    end else begin : g_mid
      always_comb begin
        case ({key, cell_sel})
          2'b10:   fb = q;
          2'b01:   fb = adj_pin_in;
          default: fb = pin_in;
        endcase
        if (bad) fb = 1'b0;
      end
    end
  endgenerate

  AST_BAD_NO_FB: assert property (@(posedge clk) disable iff (rst)
    bad |-> !fb); // R11
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_mc_pkg::*;
#(
  parameter int N_PT   = 8,
  parameter bit IS_END = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_PT-1:0] pt,
  input  logic            glb_oe,
  input  logic            pin_in,
  input  logic            adj_pin_in,
  input  logic            cfg_glb_comb,
  input  logic            cfg_glb_fam,
  input  logic            cfg_cell_sel,
  input  logic            cfg_cell_inv,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            fb_out,
  output logic            cfg_err
);
  localparam int OE_TERM = N_PT - 1;

  mc_mode_t mode;
  logic     bad;
  logic     sum_all, val_all, val_lo;
  logic     q;

  pal_mc_decode u_dec (
    .glb_comb (cfg_glb_comb),
    .glb_fam  (cfg_glb_fam),
    .cell_sel (cfg_cell_sel),
    .mode     (mode),
    .bad      (bad)
  );

  pal_mc_sum #(.N_PT(N_PT)) u_sum (
    .pt      (pt),
    .inv     (cfg_cell_inv),
    .sum_all (sum_all),
    .val_all (val_all),
    .val_lo  (val_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= val_all;
  end

  pal_mc_fbsel #(.IS_END(IS_END)) u_fb (
    .clk        (clk),
    .rst        (rst),
    .glb_comb   (cfg_glb_comb),
    .glb_fam    (cfg_glb_fam),
    .cell_sel   (cfg_cell_sel),
    .bad        (bad),
    .q          (q),
    .pin_in     (pin_in),
    .adj_pin_in (adj_pin_in),
    .fb         (fb_out)
  );

  always_comb begin
    case (mode)
      MD_REG:         begin pin_out = q;       pin_oe = glb_oe;      end
      MD_IOR, MD_ION: begin pin_out = val_lo;  pin_oe = pt[OE_TERM]; end
      MD_COMB:        begin pin_out = val_all; pin_oe = 1'b1;        end
      default:        begin pin_out = 1'b0;    pin_oe = 1'b0;        end
    endcase
  end

  assign cfg_err = bad;

  AST_BAD_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !pin_oe && !pin_out); // R11
  AST_DIN_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    ({cfg_glb_comb, cfg_glb_fam, cfg_cell_sel} == 3'b101) |-> !pin_oe); // R7
  AST_IO_OE_TERM: assert property (@(posedge clk) disable iff (rst)
    (cfg_glb_fam && cfg_cell_sel) |-> pin_oe == pt[OE_TERM]); // R4
  AST_REG_FB_EQ: assert property (@(posedge clk) disable iff (rst)
    ({cfg_glb_comb, cfg_glb_fam, cfg_cell_sel} == 3'b010) |-> fb_out == pin_out); // R2
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (({cfg_glb_comb, cfg_glb_fam, cfg_cell_sel} == 3'b010) && $past(!rst)
     && $past({cfg_glb_comb, cfg_glb_fam, cfg_cell_sel} == 3'b010))
    |-> pin_out == $past(sum_all ^ cfg_cell_inv)); // R2
endmodule

// File: tb/test_pal_macrocell.sv
module test_pal_macrocell;
  localparam int N_PT = 8;
  localparam int NV   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_PT-1:0] pt = '0;
  logic glb_oe = 1'b0, pin_in = 1'b0, adj_pin_in = 1'b0;
  logic c_comb = 1'b0, c_fam = 1'b1, c_sel = 1'b0, c_inv = 1'b0;
  logic out_a, oe_a, fb_a, err_a;
  logic out_b, oe_b, fb_b, err_b;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pal_macrocell #(.N_PT(N_PT), .IS_END(1'b0)) i_pal_macrocell (
    .clk(clk), .rst(rst), .pt(pt), .glb_oe(glb_oe), .pin_in(pin_in),
    .adj_pin_in(adj_pin_in), .cfg_glb_comb(c_comb), .cfg_glb_fam(c_fam),
    .cfg_cell_sel(c_sel), .cfg_cell_inv(c_inv),
    .pin_out(out_a), .pin_oe(oe_a), .fb_out(fb_a), .cfg_err(err_a));

  pal_macrocell #(.N_PT(N_PT), .IS_END(1'b1)) i_pal_macrocell_end (
    .clk(clk), .rst(rst), .pt(pt), .glb_oe(glb_oe), .pin_in(pin_in),
    .adj_pin_in(adj_pin_in), .cfg_glb_comb(c_comb), .cfg_glb_fam(c_fam),
    .cfg_cell_sel(c_sel), .cfg_cell_inv(c_inv),
    .pin_out(out_b), .pin_oe(oe_b), .fb_out(fb_b), .cfg_err(err_b));

  // {comb,fam,sel,inv}, pt, {glb_oe,pin_in,adj}, expected {out,oe,fb,fb_end,err}
  localparam logic [19:0] VEC [NV] = '{
    {4'b1000, 8'h00, 3'b101, 5'b01000},
    {4'b1000, 8'h80, 3'b010, 5'b11100},
    {4'b1001, 8'h04, 3'b000, 5'b01000},
    {4'b1001, 8'h00, 3'b011, 5'b11100},
    {4'b1010, 8'hFF, 3'b101, 5'b00110},
    {4'b1011, 8'h00, 3'b010, 5'b00000},
    {4'b1110, 8'h80, 3'b011, 5'b01110},
    {4'b1110, 8'h01, 3'b001, 5'b10010},
    {4'b1111, 8'h81, 3'b110, 5'b01100},
    {4'b0110, 8'h80, 3'b010, 5'b01110},
    {4'b0111, 8'h40, 3'b001, 5'b00000},
    {4'b0110, 8'h7F, 3'b100, 5'b10000},
    {4'b0000, 8'hFF, 3'b111, 5'b00001},
    {4'b0011, 8'hFF, 3'b111, 5'b00001},
    {4'b1100, 8'hFF, 3'b111, 5'b00001},
    {4'b1001, 8'hFF, 3'b111, 5'b01100}
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] c);
    string s;
    case (c[3:1])
      3'b011, 3'b111: s = "R1 R4 R5";
      3'b100:         s = "R1 R6";
      3'b101:         s = "R1 R7";
      default:        s = "R11";
    endcase
    if (c[0] && s != "R11") s = {s, " R8"};
    return s;
  endfunction

  function automatic string end_tag(input logic [3:0] c);
    if (c[3:1] == 3'b100) return "R9";
    if (c[3:1] == 3'b111) return "R10";
    return req_of(c);
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // reset in registered mode
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #2;
    chk("R12", "out after reset", out_a, 1'b0);
    chk("R12", "fb after reset", fb_a, 1'b0);
    chk("R11", "err legal", err_a, 1'b0);

    // registered path
    @(negedge clk); pt = 8'h01; c_inv = 1'b0; glb_oe = 1'b1; #2;
    chk("R2", "out holds before edge", out_a, 1'b0);
    @(posedge clk); #2;
    chk("R2", "out after capture", out_a, 1'b1);
    chk("R2", "fb from register", fb_a, 1'b1);
    chk("R10", "end fb registered", fb_b, 1'b1);
    chk("R3", "oe follows glb_oe", oe_a, 1'b1);
    @(negedge clk); glb_oe = 1'b0; #2;
    chk("R3", "oe off with glb_oe", oe_a, 1'b0);
    chk("R2", "out unchanged", out_a, 1'b1);
    @(negedge clk); c_inv = 1'b1; @(posedge clk); #2;
    chk("R8", "registered inverted 1", out_a, 1'b0);
    @(negedge clk); pt = 8'h00; @(posedge clk); #2;
    chk("R8", "registered inverted 0", out_a, 1'b1);
    @(negedge clk); rst = 1'b1; @(posedge clk); #2;
    chk("R12", "sync reset clears", out_a, 1'b0);
    @(negedge clk); rst = 1'b0; c_inv = 1'b0; pt = 8'h80;
    @(posedge clk); #2;
    chk("R2", "eighth term counts", out_a, 1'b1);

    // combinational modes from the vector table
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      @(negedge clk);
      {c_comb, c_fam, c_sel, c_inv} = v[19:16];
      pt = v[15:8];
      {glb_oe, pin_in, adj_pin_in} = v[7:5];
      #2;
      chk(req_of(v[19:16]), $sformatf("vec%0d out", i), out_a, v[4]);
      chk(req_of(v[19:16]), $sformatf("vec%0d oe", i), oe_a, v[3]);
      chk(req_of(v[19:16]), $sformatf("vec%0d fb", i), fb_a, v[2]);
      chk(end_tag(v[19:16]), $sformatf("vec%0d end fb", i), fb_b, v[1]);
      chk(req_of(v[19:16]), $sformatf("vec%0d err", i), err_a, v[0]);
      chk(req_of(v[19:16]), $sformatf("vec%0d end out", i), out_b, v[4]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule